// File: doc/BRIEF.md
# Banked GPIO Register Block

This block is the register core of a 128-pin general-purpose I/O controller. The pins are grouped into four banks of 32. Pin number p belongs to bank p[6:5] and sits at bit p[4:0] of that bank's registers. A simple single-cycle bus port (select, write enable, byte address, write data) reaches these registers per bank:

- a direction mask;
- an output latch, changed only through set-only and clear-only write ports;
- rising-edge and falling-edge enable masks;
- two alternate-function words.

The block drives the output pin vector and a per-pin strobe that marks a change in the driven level. It also exports the direction, enable and alternate-function state to neighbouring logic.

Edge detection lives in a separate block. Its status bits come in on `edge_stat`. Reads of the edge-status registers return those bits. Writes to the edge-status registers are forwarded as a one-cycle clear mask on `edge_clr`.

The register map is irregular. Banks 0 to 2 occupy consecutive words. The fourth bank's copy of every per-bank register except the alternate-function words sits 0x100 above the bank-0 copy. The alternate-function words of all four banks are interleaved lower/upper in one run. The map is computed from the address rather than held in a table.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every register is zero. `pin_out`, `pin_dir`, `rise_en`, `fall_en`, `alt_fn`, `pin_strobe`, `edge_clr` and `bus_rdata` are all zero.
- R2: Direction, rising-enable and falling-enable registers of bank b store the written word and read it back. They appear on `pin_dir`, `rise_en` and `fall_en` at bits [32b+31:32b]. Register offsets for banks 0, 1, 2 and 3:
  - direction: 0x00C, 0x010, 0x014, 0x10C;
  - rising enable: 0x030, 0x034, 0x038, 0x130;
  - falling enable: 0x03C, 0x040, 0x044, 0x13C.
- R3: A write to a set register ORs the data into that bank's output latch. Set offsets for banks 0 to 3 are 0x018, 0x01C, 0x020 and 0x118.
- R4: A write to a clear register clears every latch bit whose data bit is 1. Clear offsets for banks 0 to 3 are 0x024, 0x028, 0x02C and 0x124.
- R5: Set and clear registers read as zero whatever the latch holds.
- R6: A level read of bank b returns (latch AND direction) OR (`pin_in` slice AND NOT direction). A direction bit of 1 marks an output. `pin_in` is taken at the clock edge of the request. Level offsets for banks 0 to 3 are 0x000, 0x004, 0x008 and 0x100.
- R7: An access has no effect on any register and reads as zero in each of these cases:
  - the address is 0x200 or above;
  - the address has bits [1:0] not zero;
  - the address is any other offset not listed in R2 to R6, R11 or R12.
- R8: `pin_out` equals latch AND direction for every pin. It takes its new value at the clock edge that accepts the write.
- R9: `pin_strobe` is high for exactly one cycle, together with the `pin_out` update, on precisely those pins whose driven level changed. It is zero otherwise.
- R10: Read data appears on `bus_rdata` in the cycle after the request edge. `bus_rdata` is zero in every cycle that does not follow a read request.
- R11: Edge-status reads of bank b return `edge_stat` bits [32b+31:32b]. A write there drives the data onto `edge_clr` bits [32b+31:32b] for one cycle and leaves all other `edge_clr` bits zero. Offsets for banks 0 to 3 are 0x048, 0x04C, 0x050 and 0x148.
- R12: Bank b has a lower alternate-function word at 0x054+8b and an upper word at 0x058+8b. Each reads back its value. On `alt_fn`, the lower word drives bits [64b+31:64b] and the upper word drives bits [64b+63:64b+32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 128 | Sampled pad input levels |
| edge_stat | input | 128 | Edge status from the edge-detect block |
| pin_out | output | 128 | Driven level, latch AND direction |
| pin_dir | output | 128 | Direction, 1 = output |
| pin_strobe | output | 128 | One-cycle change marker per pin |
| rise_en | output | 128 | Rising-edge enable masks |
| fall_en | output | 128 | Falling-edge enable masks |
| alt_fn | output | 256 | Alternate-function words, two per bank |
| edge_clr | output | 128 | One-cycle edge-status clear mask |

## Verification
Writes land at the accepting clock edge. `pin_out`, `pin_dir`, the enable and alternate-function outputs, `pin_strobe` and `edge_clr` therefore all carry their new value in the cycle right after that edge. Read data follows one cycle after the request edge. The bench drives every access on a falling edge and samples on the next falling edge, which sits exactly in that cycle. It samples once more a cycle later to confirm that `pin_strobe`, `edge_clr` and `bus_rdata` have returned to zero. Expected values come from a bench-side model of the latch, direction and configuration words, updated from the requirement text.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // The register map places exactly four banks of 32 pins.
    localparam int NUM_BANKS  = 4;
    localparam int BANK_WIDTH = 32;
    localparam int NUM_PINS   = NUM_BANKS * BANK_WIDTH;

    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_LEVEL = 4'd1,
        K_DIR   = 4'd2,
        K_SET   = 4'd3,
        K_CLR   = 4'd4,
        K_RISE  = 4'd5,
        K_FALL  = 4'd6,
        K_EDGE  = 4'd7,
        K_ALTL  = 4'd8,
        K_ALTU  = 4'd9
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  bank;
    } reg_sel_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    // Word index inside a 256-byte half of the map.
    logic [5:0] idx;
    logic [3:0] grp;
    logic [1:0] rem;
    logic [2:0] alt_j;

    assign idx   = addr_i[7:2];
    assign grp   = 4'(idx / 6'd3);
    assign rem   = 2'(idx % 6'd3);
    assign alt_j = 3'(idx - 6'd21);

    always_comb begin
        sel_o.kind = K_NONE;
        sel_o.bank = 2'd0;
        if (addr_i[ADDR_W-1:9] == '0 && addr_i[1:0] == 2'b00) begin
            if (!addr_i[8]) begin
                // Seven groups of three words for banks 0..2, then
                // eight interleaved alternate-function words.
                if (idx < 6'd21) begin
                    sel_o.kind = reg_kind_e'(grp + 4'd1);
                    sel_o.bank = rem;
                end else if (idx < 6'd29) begin
                    sel_o.kind = alt_j[0] ? K_ALTU : K_ALTL;
                    sel_o.bank = alt_j[2:1];
                end
            end else if (idx < 6'd21 && rem == 2'd0) begin
                // Bank 3 mirrors the bank-0 word 0x100 higher.
                sel_o.kind = reg_kind_e'(grp + 4'd1);
                sel_o.bank = 2'd3;
            end
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
(
    input  reg_sel_t                    sel_i,
    input  logic [NUM_PINS-1:0]         dir_i,
    input  logic [NUM_PINS-1:0]         latch_i,
    input  logic [NUM_PINS-1:0]         rise_i,
    input  logic [NUM_PINS-1:0]         fall_i,
    input  logic [2*NUM_PINS-1:0]       alt_i,
    input  logic [NUM_PINS-1:0]         pin_in_i,
    input  logic [NUM_PINS-1:0]         edge_stat_i,
    output logic [BANK_WIDTH-1:0]       rd_val_o
);

    logic [BANK_WIDTH-1:0] dir_w, latch_w, in_w;
    int unsigned           base;
    int unsigned           alt_base;

    always_comb begin
        base     = 32'(sel_i.bank) * BANK_WIDTH;
        alt_base = 32'(sel_i.bank) * 2 * BANK_WIDTH;
        dir_w    = dir_i[base +: BANK_WIDTH];
        latch_w  = latch_i[base +: BANK_WIDTH];
        in_w     = pin_in_i[base +: BANK_WIDTH];
        case (sel_i.kind)
            K_LEVEL: rd_val_o = (latch_w & dir_w) | (in_w & ~dir_w);
            K_DIR:   rd_val_o = dir_w;
            K_RISE:  rd_val_o = rise_i[base +: BANK_WIDTH];
            K_FALL:  rd_val_o = fall_i[base +: BANK_WIDTH];
            K_EDGE:  rd_val_o = edge_stat_i[base +: BANK_WIDTH];
            K_ALTL:  rd_val_o = alt_i[alt_base +: BANK_WIDTH];
            K_ALTU:  rd_val_o = alt_i[alt_base + BANK_WIDTH +: BANK_WIDTH];
            default: rd_val_o = '0;   // set/clear are write-only, holes read 0
        endcase
    end

endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
    import gpio_bank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  reg_sel_t                sel_i,
    input  logic [BANK_WIDTH-1:0]   wdata_i,
    input  logic [BANK_WIDTH-1:0]   rd_val_i,
    output logic [NUM_PINS-1:0]     dir_o,
    output logic [NUM_PINS-1:0]     latch_o,
    output logic [NUM_PINS-1:0]     rise_o,
    output logic [NUM_PINS-1:0]     fall_o,
    output logic [2*NUM_PINS-1:0]   alt_o,
    output logic [NUM_PINS-1:0]     eff_o,
    output logic [NUM_PINS-1:0]     strobe_o,
    output logic [NUM_PINS-1:0]     eclr_o,
    output logic [BANK_WIDTH-1:0]   rdata_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_WIDTH-1:0]   dir;
        logic [NUM_BANKS-1:0][BANK_WIDTH-1:0]   latch;
        logic [NUM_BANKS-1:0][BANK_WIDTH-1:0]   rise;
        logic [NUM_BANKS-1:0][BANK_WIDTH-1:0]   fall;
        logic [2*NUM_BANKS-1:0][BANK_WIDTH-1:0] alt;
        logic [NUM_PINS-1:0]                    eff;
        logic [NUM_PINS-1:0]                    strobe;
        logic [NUM_BANKS-1:0][BANK_WIDTH-1:0]   eclr;
        logic [BANK_WIDTH-1:0]                  rdata;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = '0;
        st_d.eclr   = '0;
        st_d.rdata  = rd_en_i ? rd_val_i : '0;
        if (wr_en_i) begin
            case (sel_i.kind)
                K_DIR:  st_d.dir[sel_i.bank]   = wdata_i;
                K_SET:  st_d.latch[sel_i.bank] = st_q.latch[sel_i.bank] | wdata_i;
                K_CLR:  st_d.latch[sel_i.bank] = st_q.latch[sel_i.bank] & ~wdata_i;
                K_RISE: st_d.rise[sel_i.bank]  = wdata_i;
                K_FALL: st_d.fall[sel_i.bank]  = wdata_i;
                K_EDGE: st_d.eclr[sel_i.bank]  = wdata_i;
                K_ALTL: st_d.alt[{sel_i.bank, 1'b0}] = wdata_i;
                K_ALTU: st_d.alt[{sel_i.bank, 1'b1}] = wdata_i;
                default: ;
            endcase
        end
        // Driven level and its change marker come from the next state so
        // both update at the edge that accepts the write.
        st_d.eff    = st_d.latch & st_d.dir;
        st_d.strobe = st_d.eff ^ st_q.eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o    = st_q.dir;
    assign latch_o  = st_q.latch;
    assign rise_o   = st_q.rise;
    assign fall_o   = st_q.fall;
    assign alt_o    = st_q.alt;
    assign eff_o    = st_q.eff;
    assign strobe_o = st_q.strobe;
    assign eclr_o   = st_q.eclr;
    assign rdata_o  = st_q.rdata;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BANK_WIDTH-1:0]   bus_wdata,
    output logic [BANK_WIDTH-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0]     pin_in,
    input  logic [NUM_PINS-1:0]     edge_stat,
    output logic [NUM_PINS-1:0]     pin_out,
    output logic [NUM_PINS-1:0]     pin_dir,
    output logic [NUM_PINS-1:0]     pin_strobe,
    output logic [NUM_PINS-1:0]     rise_en,
    output logic [NUM_PINS-1:0]     fall_en,
    output logic [2*NUM_PINS-1:0]   alt_fn,
    output logic [NUM_PINS-1:0]     edge_clr
);

    reg_sel_t              sel;
    logic [NUM_PINS-1:0]   latch;
    logic [BANK_WIDTH-1:0] rd_val;
    logic                  wr_en, rd_en;

    assign wr_en = bus_sel & bus_we;
    assign rd_en = bus_sel & ~bus_we;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    gpio_read_mux rmux_i (
        .sel_i       (sel),
        .dir_i       (pin_dir),
        .latch_i     (latch),
        .rise_i      (rise_en),
        .fall_i      (fall_en),
        .alt_i       (alt_fn),
        .pin_in_i    (pin_in),
        .edge_stat_i (edge_stat),
        .rd_val_o    (rd_val)
    );

    gpio_reg_core core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .sel_i    (sel),
        .wdata_i  (bus_wdata),
        .rd_val_i (rd_val),
        .dir_o    (pin_dir),
        .latch_o  (latch),
        .rise_o   (rise_en),
        .fall_o   (fall_en),
        .alt_o    (alt_fn),
        .eff_o    (pin_out),
        .strobe_o (pin_strobe),
        .eclr_o   (edge_clr),
        .rdata_o  (bus_rdata)
    );

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [BANK_WIDTH-1:0] bus_rdata,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic [NUM_PINS-1:0]   pin_dir,
    input logic [NUM_PINS-1:0]   pin_strobe,
    input logic [NUM_PINS-1:0]   edge_clr
);

    a_r8_out_within_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_dir) == '0);

    a_r9_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        pin_strobe == (pin_out ^ $past(pin_out)));

    a_r10_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> bus_rdata == '0);

    a_r3_set_never_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 12'h018) |=>
            (pin_out & $past(pin_out)) == $past(pin_out));

    a_r7_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr >= 12'h200) |=> bus_rdata == '0);

    a_r7_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr >= 12'h200) |=>
            ($stable(pin_dir) && $stable(pin_out)));

    a_r11_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_clr != '0) |-> $past(bus_sel && bus_we));

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .pin_dir    (pin_dir),
    .pin_strobe (pin_strobe),
    .edge_clr   (edge_clr)
);

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;

    localparam int KL = 0, KD = 1, KS = 2, KC = 3, KR = 4, KF = 5, KE = 6, KAL = 7, KAU = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0, edge_stat = '0;
    logic [127:0] pin_out, pin_dir, pin_strobe, rise_en, fall_en, edge_clr;
    logic [255:0] alt_fn;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [31:0] m_dir [4];
    logic [31:0] m_lat [4];
    logic [31:0] m_rise [4];
    logic [31:0] m_fall [4];
    logic [31:0] m_alt [8];

    always #5 clk = ~clk;

    gpio_bank_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .edge_stat(edge_stat), .pin_out(pin_out),
        .pin_dir(pin_dir), .pin_strobe(pin_strobe), .rise_en(rise_en),
        .fall_en(fall_en), .alt_fn(alt_fn), .edge_clr(edge_clr)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] addr_of(input int kind, input int bank);
        logic [11:0] base;
        case (kind)
            KL: base = 12'h000;  KD: base = 12'h00C;  KS: base = 12'h018;
            KC: base = 12'h024;  KR: base = 12'h030;  KF: base = 12'h03C;
            KE: base = 12'h048;
            KAL: return 12'h054 + 12'(8 * bank);
            default: return 12'h058 + 12'(8 * bank);
        endcase
        return (bank == 3) ? base + 12'h100 : base + 12'(4 * bank);
    endfunction

    function automatic logic [127:0] m_out();
        logic [127:0] v;
        for (int b = 0; b < 4; b++) v[32*b +: 32] = m_lat[b] & m_dir[b];
        return v;
    endfunction

    function automatic logic [127:0] m_dirv();
        logic [127:0] v;
        for (int b = 0; b < 4; b++) v[32*b +: 32] = m_dir[b];
        return v;
    endfunction

    // Drive at a falling edge; on return the next falling edge has passed,
    // so results of the accepting rising edge are visible.
    task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr_reg(input int kind, input int bank, input logic [31:0] d);
        logic [127:0] prev, eclr_exp;
        prev = m_out();
        eclr_exp = '0;
        case (kind)
            KD: m_dir[bank] = d;
            KS: m_lat[bank] = m_lat[bank] | d;
            KC: m_lat[bank] = m_lat[bank] & ~d;
            KR: m_rise[bank] = d;
            KF: m_fall[bank] = d;
            KE: eclr_exp[32*bank +: 32] = d;
            KAL: m_alt[2*bank] = d;
            KAU: m_alt[2*bank+1] = d;
            default: ;
        endcase
        bus_op(1'b1, addr_of(kind, bank), d);
        chk("R8 pin_out", pin_out, m_out());
        chk("R9 strobe", pin_strobe, prev ^ m_out());
        chk("R2 pin_dir", pin_dir, m_dirv());
        chk("R11 edge_clr", edge_clr, eclr_exp);
        @(negedge clk);
        chk("R9 strobe idle", pin_strobe, '0);
        chk("R11 edge_clr idle", edge_clr, '0);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_op(1'b0, a, '0);
        chk(req, bus_rdata, exp);
        @(negedge clk);
        chk("R10 rdata idle", bus_rdata, '0);
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_dir", pin_dir, '0);
        chk("R1 rise_en", rise_en, '0);
        chk("R1 fall_en", fall_en, '0);
        chk("R1 alt_fn", alt_fn, '0);
        chk("R1 strobe", pin_strobe, '0);
        chk("R1 edge_clr", edge_clr, '0);
        chk("R1 rdata", bus_rdata, '0);
        rd_chk("R1 level", addr_of(KL, 0), 32'h0);
    endtask

    task automatic t_map();
        for (int b = 0; b < 4; b++) begin
            wr_reg(KD, b, 32'h1111_0000 * (b + 1) + 32'h0000_00F0);
            wr_reg(KR, b, 32'hA5A5_0000 ^ (32'h13 << b));
            wr_reg(KF, b, 32'h5A00_3C00 + b);
        end
        for (int b = 0; b < 4; b++) begin
            rd_chk("R2 dir read", addr_of(KD, b), m_dir[b]);
            rd_chk("R2 rise read", addr_of(KR, b), m_rise[b]);
            rd_chk("R2 fall read", addr_of(KF, b), m_fall[b]);
            chk("R2 rise_en", rise_en[32*b +: 32], m_rise[b]);
            chk("R2 fall_en", fall_en[32*b +: 32], m_fall[b]);
        end
        for (int w = 0; w < 8; w++) wr_reg((w % 2) ? KAU : KAL, w / 2, 32'hC0DE_0000 + w * 32'h0101);
        for (int w = 0; w < 8; w++) begin
            rd_chk("R12 alt read", addr_of((w % 2) ? KAU : KAL, w / 2), m_alt[w]);
            chk("R12 alt_fn", alt_fn[32*w +: 32], m_alt[w]);
        end
    endtask

    task automatic t_setclr();
        wr_reg(KD, 0, 32'h0000_FFFF);
        wr_reg(KS, 0, 32'h00FF_00FF);   // R3
        wr_reg(KC, 0, 32'h0F00_00F0);   // R4
        wr_reg(KD, 0, 32'hFFFF_FFFF);   // R8 direction change reveals latch
        wr_reg(KD, 3, 32'hF0F0_F0F0);
        wr_reg(KS, 3, 32'hFFFF_0000);   // R3 bank 3 at 0x118
        wr_reg(KC, 3, 32'h00F0_0000);   // R4 bank 3 at 0x124
        wr_reg(KS, 1, 32'h8000_0001);
        wr_reg(KS, 2, 32'h0000_0000);
        for (int b = 0; b < 4; b++) begin
            rd_chk("R5 set reads zero", addr_of(KS, b), 32'h0);
            rd_chk("R5 clr reads zero", addr_of(KC, b), 32'h0);
        end
    endtask

    task automatic t_level();
        pin_in = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        for (int b = 0; b < 4; b++)
            rd_chk("R6 level", addr_of(KL, b),
                   (m_lat[b] & m_dir[b]) | (pin_in[32*b +: 32] & ~m_dir[b]));
        pin_in = ~pin_in;
        for (int b = 0; b < 4; b++)
            rd_chk("R6 level inv", addr_of(KL, b),
                   (m_lat[b] & m_dir[b]) | (pin_in[32*b +: 32] & ~m_dir[b]));
    endtask

    task automatic t_edge();
        edge_stat = 128'hDEAD_BEEF_0BAD_F00D_1234_5678_CAFE_D00D;
        for (int b = 0; b < 4; b++)
            rd_chk("R11 edge read", addr_of(KE, b), edge_stat[32*b +: 32]);
        wr_reg(KE, 1, 32'h0000_A5A5);
        wr_reg(KE, 3, 32'hFFFF_FFFF);
    endtask

    task automatic t_bad();
        logic [11:0] bad [6];
        logic [127:0] o, d, r, f;
        logic [255:0] al;
        bad[0] = 12'h200; bad[1] = 12'h07C; bad[2] = 12'h002;
        bad[3] = 12'h0FC; bad[4] = 12'h104; bad[5] = 12'h30C;
        for (int i = 0; i < 6; i++) begin
            o = pin_out; d = pin_dir; r = rise_en; f = fall_en; al = alt_fn;
            bus_op(1'b1, bad[i], 32'hFFFF_FFFF);
            chk("R7 pin_out kept", pin_out, o);
            chk("R7 pin_dir kept", pin_dir, d);
            chk("R7 enables kept", {r, f}, {rise_en, fall_en});
            chk("R7 alt kept", alt_fn, al);
            chk("R7 no strobe", pin_strobe, '0);
            chk("R7 no edge_clr", edge_clr, '0);
            @(negedge clk);
            rd_chk("R7 read zero", bad[i], 32'h0);
        end
    endtask

    initial begin
        for (int b = 0; b < 4; b++) begin
            m_dir[b] = '0; m_lat[b] = '0; m_rise[b] = '0; m_fall[b] = '0;
        end
        for (int w = 0; w < 8; w++) m_alt[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_setclr();
        t_level();
        t_edge();
        t_bad();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule